// File: doc/BRIEF.md
# Shift and Rotate Unit

A purely combinational unit that sits on a 32-bit integer datapath and performs every shift and rotate form in one place: zero-filling and sign-preserving shifts, funnel shifts that pull bits in from a second operand, plain rotates, and rotates that run through the carry flag as a 33rd bit. Each operation returns the shifted value and a new carry flag, so the unit can feed a flags register directly.

The count is taken either from an immediate field or from a count register input, chosen by a select pin. Only the count modulo the data width (its low five bits) is used. A reduced count of zero passes the operand and the incoming carry through untouched. An opcode outside the defined set also passes the operand and carry through, and raises an illegal-operation output.

Top module: `srot_unit`

## Requirements
- R1: Opcodes 0 (logical left) and 1 (arithmetic left) give identical results: the operand moves up by n, the low n bits become 0, and carry_o is operand bit 32-n.
- R2: Opcode 2 (logical right) moves the operand down by n, fills the top n bits with 0, and sets carry_o to operand bit n-1.
- R3: Opcode 3 (arithmetic right) moves the operand down by n, fills the top n bits with copies of operand bit 31, and sets carry_o to operand bit n-1.
- R4: Opcode 4 (double left) moves the operand up by n and fills the low n bits with the top n bits of the second operand (result bit i is fill bit 32+i-n for i<n); carry_o is operand bit 32-n.
- R5: Opcode 5 (double right) moves the operand down by n and fills the top n bits with the low n bits of the second operand (result bit i is fill bit i+n-32 for i+n>=32); carry_o is operand bit n-1.
- R6: Opcode 6 rotates left by n (bit i goes to (i+n) mod 32) with carry_o equal to result bit 0; opcode 7 rotates right by n with carry_o equal to result bit 31.
- R7: Opcodes 8 (left) and 9 (right) rotate the 33-bit ring {carry_i, operand} by n; the low 32 ring bits form the result and the top ring bit forms carry_o.
- R8: With cnt_sel_i = 1 the count is cnt_reg_i, with cnt_sel_i = 0 it is cnt_imm_i; the unselected input has no effect, and only the selected count modulo 32 (its low 5 bits) is used.
- R9: For a legal opcode and a reduced count of 0, result_o equals the operand and carry_o equals carry_i.
- R10: Opcodes 10 to 15 give result_o equal to the operand, carry_o equal to carry_i and illegal_o = 1; for opcodes 0 to 9 illegal_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| opnd_i | input | 32 | Operand to shift or rotate |
| fill_i | input | 32 | Second operand supplying bits for double shifts |
| cnt_imm_i | input | 8 | Count from the immediate field |
| cnt_reg_i | input | 8 | Count from the count register |
| cnt_sel_i | input | 1 | 1 selects cnt_reg_i, 0 selects cnt_imm_i |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted or rotated value |
| carry_o | output | 1 | New carry flag |
| illegal_o | output | 1 | Opcode outside the defined set |

## Verification
The unit holds no state, so any fault in the count reduction, the fill selection or the carry tap shows up on result_o or carry_o in the same evaluation as the inputs that expose it. A wrong count mask appears only for counts with upper bits set or multiples of 32, and a wrong carry tap appears only at specific bit positions, so the bench sweeps every count for every opcode over operands with distinct bit patterns and both carry values. Through-carry rotates are the most sensitive case: an off-by-one in the 33-bit ring moves the carry bit into the result and is visible at every nonzero count.

// File: rtl/srot_pkg.sv
package srot_pkg;

    localparam int SR_W      = 32;
    localparam int SR_CNT_W  = $clog2(SR_W);
    localparam int SR_RING_W = SR_W + 1;
    localparam int SR_OP_W   = 4;

    typedef enum logic [SR_OP_W-1:0] {
        OP_SHL  = 4'd0,
        OP_SAL  = 4'd1,
        OP_SHR  = 4'd2,
        OP_SAR  = 4'd3,
        OP_SHLD = 4'd4,
        OP_SHRD = 4'd5,
        OP_ROL  = 4'd6,
        OP_ROR  = 4'd7,
        OP_RCL  = 4'd8,
        OP_RCR  = 4'd9
    } sr_op_e;

    localparam logic [SR_OP_W-1:0] OP_LAST = 4'd9;

    typedef struct packed {
        logic [SR_W-1:0] val;
        logic            cf;
    } sr_res_t;

    function automatic logic op_is_legal(input logic [SR_OP_W-1:0] op);
        return op <= OP_LAST;
    endfunction

    function automatic sr_res_t pass_through(input logic [SR_W-1:0] v, input logic c);
        sr_res_t r;
        r.val = v;
        r.cf  = c;
        return r;
    endfunction

endpackage

// File: rtl/srot_count.sv
module srot_count
    import srot_pkg::*;
#(
    parameter int RAW_W = 8
) (
    input  logic [RAW_W-1:0]    cnt_imm_i,
    input  logic [RAW_W-1:0]    cnt_reg_i,
    input  logic                cnt_sel_i,
    output logic [SR_CNT_W-1:0] cnt_o,
    output logic                cnt_zero_o
);
    logic [RAW_W-1:0] raw;

    always_comb raw = cnt_sel_i ? cnt_reg_i : cnt_imm_i;

    generate
        if ((SR_W & (SR_W - 1)) == 0) begin : g_pow2
            logic [RAW_W-1:0] masked;
            always_comb masked = raw & RAW_W'(SR_W - 1);
            always_comb cnt_o  = masked[SR_CNT_W-1:0];
        end else begin : g_mod
            logic [RAW_W-1:0] modded;
            always_comb modded = raw % RAW_W'(SR_W);
            always_comb cnt_o  = modded[SR_CNT_W-1:0];
        end
    endgenerate

    always_comb cnt_zero_o = (cnt_o == '0);
endmodule

// File: rtl/srot_shift.sv
module srot_shift
    import srot_pkg::*;
(
    input  logic [SR_OP_W-1:0]  op_i,
    input  logic [SR_W-1:0]     opnd_i,
    input  logic [SR_W-1:0]     fill_i,
    input  logic [SR_CNT_W-1:0] cnt_i,
    output sr_res_t             res_o
);
    logic [2*SR_W-1:0] up_ext;
    logic [2*SR_W-1:0] dn_ext;
    logic [2*SR_W-1:0] sar_ext;
    logic [2*SR_W:0]   dl_ext;
    logic [2*SR_W:0]   dr_ext;

    always_comb begin
        up_ext  = {{SR_W{1'b0}}, opnd_i} << cnt_i;
        dn_ext  = {opnd_i, {SR_W{1'b0}}} >> cnt_i;
        sar_ext = $unsigned($signed({opnd_i, {SR_W{1'b0}}}) >>> cnt_i);
        dl_ext  = {1'b0, opnd_i, fill_i} << cnt_i;
        dr_ext  = {fill_i, opnd_i, 1'b0} >> cnt_i;
    end

    always_comb begin
        unique case (op_i)
            OP_SHL, OP_SAL: begin
                res_o.val = up_ext[SR_W-1:0];
                res_o.cf  = up_ext[SR_W];
            end
            OP_SHR: begin
                res_o.val = dn_ext[2*SR_W-1:SR_W];
                res_o.cf  = dn_ext[SR_W-1];
            end
            OP_SAR: begin
                res_o.val = sar_ext[2*SR_W-1:SR_W];
                res_o.cf  = sar_ext[SR_W-1];
            end
            OP_SHLD: begin
                res_o.val = dl_ext[2*SR_W-1:SR_W];
                res_o.cf  = dl_ext[2*SR_W];
            end
            OP_SHRD: begin
                res_o.val = dr_ext[SR_W:1];
                res_o.cf  = dr_ext[0];
            end
            default: begin
                res_o.val = opnd_i;
                res_o.cf  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/srot_rotate.sv
module srot_rotate
    import srot_pkg::*;
(
    input  logic [SR_OP_W-1:0]  op_i,
    input  logic [SR_W-1:0]     opnd_i,
    input  logic                carry_i,
    input  logic [SR_CNT_W-1:0] cnt_i,
    output sr_res_t             res_o
);
    logic [2*SR_W-1:0]      rl_dbl;
    logic [2*SR_W-1:0]      rr_dbl;
    logic [SR_RING_W-1:0]   ring;
    logic [2*SR_RING_W-1:0] cl_dbl;
    logic [2*SR_RING_W-1:0] cr_dbl;
    logic [SR_RING_W-1:0]   cl_ring;
    logic [SR_RING_W-1:0]   cr_ring;

    always_comb begin
        rl_dbl  = {opnd_i, opnd_i} << cnt_i;
        rr_dbl  = {opnd_i, opnd_i} >> cnt_i;
        ring    = {carry_i, opnd_i};
        cl_dbl  = {ring, ring} << cnt_i;
        cr_dbl  = {ring, ring} >> cnt_i;
        cl_ring = cl_dbl[2*SR_RING_W-1:SR_RING_W];
        cr_ring = cr_dbl[SR_RING_W-1:0];
    end

    always_comb begin
        unique case (op_i)
            OP_ROL: begin
                res_o.val = rl_dbl[2*SR_W-1:SR_W];
                res_o.cf  = rl_dbl[SR_W];
            end
            OP_ROR: begin
                res_o.val = rr_dbl[SR_W-1:0];
                res_o.cf  = rr_dbl[SR_W-1];
            end
            OP_RCL: begin
                res_o.val = cl_ring[SR_W-1:0];
                res_o.cf  = cl_ring[SR_W];
            end
            OP_RCR: begin
                res_o.val = cr_ring[SR_W-1:0];
                res_o.cf  = cr_ring[SR_W];
            end
            default: begin
                res_o.val = opnd_i;
                res_o.cf  = carry_i;
            end
        endcase
    end
endmodule

// File: rtl/srot_unit.sv
module srot_unit
    import srot_pkg::*;
#(
    parameter int CNT_IN_W = 8
) (
    input  logic [SR_OP_W-1:0]  op_i,
    input  logic [SR_W-1:0]     opnd_i,
    input  logic [SR_W-1:0]     fill_i,
    input  logic [CNT_IN_W-1:0] cnt_imm_i,
    input  logic [CNT_IN_W-1:0] cnt_reg_i,
    input  logic                cnt_sel_i,
    input  logic                carry_i,
    output logic [SR_W-1:0]     result_o,
    output logic                carry_o,
    output logic                illegal_o
);
    logic [SR_CNT_W-1:0] cnt;
    logic                cnt_zero;
    sr_res_t             shift_res;
    sr_res_t             rot_res;
    sr_res_t             final_res;
    logic                legal;
    logic                is_rotate;

    srot_count #(.RAW_W(CNT_IN_W)) count_i (
        .cnt_imm_i  (cnt_imm_i),
        .cnt_reg_i  (cnt_reg_i),
        .cnt_sel_i  (cnt_sel_i),
        .cnt_o      (cnt),
        .cnt_zero_o (cnt_zero)
    );

    srot_shift shift_i (
        .op_i   (op_i),
        .opnd_i (opnd_i),
        .fill_i (fill_i),
        .cnt_i  (cnt),
        .res_o  (shift_res)
    );

    srot_rotate rotate_i (
        .op_i    (op_i),
        .opnd_i  (opnd_i),
        .carry_i (carry_i),
        .cnt_i   (cnt),
        .res_o   (rot_res)
    );

    always_comb begin
        legal     = op_is_legal(op_i);
        is_rotate = (op_i >= OP_ROL) && legal;
        if (!legal || cnt_zero)
            final_res = pass_through(opnd_i, carry_i);
        else if (is_rotate)
            final_res = rot_res;
        else
            final_res = shift_res;
    end

    always_comb begin
        result_o  = final_res.val;
        carry_o   = final_res.cf;
        illegal_o = !legal;
    end
endmodule

// File: rtl/srot_unit_chk.sv
module srot_unit_chk
    import srot_pkg::*;
#(
    parameter int CNT_IN_W = 8
) (
    input logic [SR_OP_W-1:0]  op_i,
    input logic [SR_W-1:0]     opnd_i,
    input logic [CNT_IN_W-1:0] cnt_imm_i,
    input logic [CNT_IN_W-1:0] cnt_reg_i,
    input logic                cnt_sel_i,
    input logic                carry_i,
    input logic [SR_W-1:0]     result_o,
    input logic                carry_o,
    input logic                illegal_o
);
    logic [CNT_IN_W-1:0] sel_cnt;
    int unsigned         n;
    logic [SR_W-1:0]     low_mask;

    always_comb begin
        sel_cnt  = cnt_sel_i ? cnt_reg_i : cnt_imm_i;
        n        = 32'(sel_cnt) % SR_W;
        low_mask = SR_W'((64'd1 << n) - 64'd1);
    end

    always_comb begin
        // R10
        if (illegal_o) begin
            a_r10_illegal_passthru: assert (result_o == opnd_i && carry_o == carry_i && op_i > OP_LAST);
        end
        // R9
        if (!illegal_o && n == 0) begin
            a_r9_zero_count_passthru: assert (result_o == opnd_i && carry_o == carry_i);
        end
        // R1
        if ((op_i == OP_SHL || op_i == OP_SAL) && n != 0) begin
            a_r1_left_zero_fill: assert ((result_o & low_mask) == '0);
        end
        // R2
        if (op_i == OP_SHR && n != 0) begin
            a_r2_right_top_clear: assert (result_o[SR_W-1] == 1'b0);
        end
        // R3
        if (op_i == OP_SAR) begin
            a_r3_sign_kept: assert (result_o[SR_W-1] == opnd_i[SR_W-1]);
        end
        // R6
        if (op_i == OP_ROL) begin
            a_r6_rol_carry_low: assert (n == 0 || carry_o == result_o[0]);
        end
        if (op_i == OP_ROR) begin
            a_r6_ror_carry_high: assert (n == 0 || carry_o == result_o[SR_W-1]);
        end
        // R7
        if ((op_i == OP_RCL || op_i == OP_RCR) && n != 0) begin
            a_r7_ring_ones_kept: assert ($countones({carry_o, result_o}) == $countones({carry_i, opnd_i}));
        end
    end
endmodule

bind srot_unit srot_unit_chk #(.CNT_IN_W(CNT_IN_W)) chk_i (
    .op_i      (op_i),
    .opnd_i    (opnd_i),
    .cnt_imm_i (cnt_imm_i),
    .cnt_reg_i (cnt_reg_i),
    .cnt_sel_i (cnt_sel_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .illegal_o (illegal_o)
);

// File: tb/srot_unit_tb_top.sv
`timescale 1ns/1ps
module srot_unit_tb_top;

    logic        clk;
    logic        rst;
    logic [3:0]  op;
    logic [31:0] opnd;
    logic [31:0] fill;
    logic [7:0]  cnt_imm;
    logic [7:0]  cnt_reg;
    logic        cnt_sel;
    logic        cin;
    logic [31:0] res;
    logic        cout;
    logic        ill;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    srot_unit dut_i (
        .op_i      (op),
        .opnd_i    (opnd),
        .fill_i    (fill),
        .cnt_imm_i (cnt_imm),
        .cnt_reg_i (cnt_reg),
        .cnt_sel_i (cnt_sel),
        .carry_i   (cin),
        .result_o  (res),
        .carry_o   (cout),
        .illegal_o (ill)
    );

    initial clk = 0;
    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] er, input logic ec, input logic ei);
        n_checks++;
        if (res !== er || cout !== ec || ill !== ei) begin
            n_fail++;
            $display("FAIL %s op=%0d opnd=%h fill=%h imm=%0d reg=%0d sel=%0d cin=%0d: got res=%h cf=%0d ill=%0d exp res=%h cf=%0d ill=%0d",
                     tag, op, opnd, fill, cnt_imm, cnt_reg, cnt_sel, cin, res, cout, ill, er, ec, ei);
        end
    endtask

    function automatic string op_tag(input int o, input int n);
        if (o > 9) return "R10";
        if (n == 0) return "R9";
        case (o)
            0, 1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6, 7: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic ref_model(input int o, input logic [31:0] a, input logic [31:0] b, input int n,
                             input logic c, output logic [31:0] r, output logic cf, output logic il);
        logic [32:0] t;
        logic [32:0] u;
        r = a; cf = c; il = (o > 9);
        if (o > 9 || n == 0) return;
        t = {c, a};
        for (int i = 0; i < 32; i++) begin
            case (o)
                0, 1: r[i] = (i >= n) ? a[i-n] : 1'b0;
                2:    r[i] = (i + n < 32) ? a[i+n] : 1'b0;
                3:    r[i] = (i + n < 32) ? a[i+n] : a[31];
                4:    r[i] = (i >= n) ? a[i-n] : b[32+i-n];
                5:    r[i] = (i + n < 32) ? a[i+n] : b[i+n-32];
                6:    r[i] = a[(i - n + 32) % 32];
                7:    r[i] = a[(i + n) % 32];
                default: ;
            endcase
        end
        case (o)
            0, 1, 4: cf = a[32-n];
            2, 3, 5: cf = a[n-1];
            6: cf = r[0];
            7: cf = r[31];
            8, 9: begin
                for (int j = 0; j < 33; j++)
                    u[j] = (o == 8) ? t[(j - n + 33) % 33] : t[(j + n) % 33];
                r = u[31:0]; cf = u[32];
            end
            default: ;
        endcase
    endtask

    task automatic apply(input int o, input logic [31:0] a, input logic [31:0] b, input logic [7:0] imm,
                         input logic [7:0] rg, input logic sel, input logic c, input string force_tag);
        logic [31:0] er;
        logic        ec;
        logic        ei;
        int          n;
        @(posedge clk);
        #1;
        op = 4'(o); opnd = a; fill = b; cnt_imm = imm; cnt_reg = rg; cnt_sel = sel; cin = c;
        n = (sel ? int'(rg) : int'(imm)) % 32;
        ref_model(o, a, b, n, c, er, ec, ei);
        @(negedge clk);
        check((force_tag != "") ? force_tag : op_tag(o, n), er, ec, ei);
    endtask

    initial begin
        logic [31:0] pats [6];
        logic [31:0] fills [3];
        pats[0] = 32'h8000_0001; pats[1] = 32'hDEAD_BEEF; pats[2] = 32'h1234_5678;
        pats[3] = 32'hFFFF_FFFF; pats[4] = 32'h0000_0000; pats[5] = 32'h7F00_80A5;
        fills[0] = 32'hC3A5_0F96; fills[1] = 32'h0000_0000; fills[2] = 32'hFFFF_FFFF;

        rst = 1; op = 0; opnd = 0; fill = 0; cnt_imm = 0; cnt_reg = 0; cnt_sel = 0; cin = 0;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        check("R9 reset", 32'h0, 1'b0, 1'b0);

        // main sweep: every opcode, every count, both sources, both carries
        for (int p = 0; p < 6; p++)
            for (int o = 0; o < 16; o++)
                for (int k = 0; k < 32; k++)
                    for (int s = 0; s < 2; s++) begin
                        logic [7:0] sc;
                        logic [7:0] decoy;
                        sc    = 8'(k + 32 * ((p + o) % 8));
                        decoy = 8'(k * 7 + 3);
                        apply(o, pats[p], fills[(p + k) % 3],
                              s ? decoy : sc, s ? sc : decoy, s[0], logic'((p + k + o) % 2), "");
                    end

        // R8: unselected count ignored, upper count bits ignored
        apply(0, 32'h0000_00FF, 32'h0, 8'd4,   8'd9,   1'b0, 1'b0, "R8 imm-selected");
        apply(0, 32'h0000_00FF, 32'h0, 8'd4,   8'd9,   1'b1, 1'b0, "R8 reg-selected");
        apply(2, 32'hF000_0000, 32'h0, 8'd36,  8'd0,   1'b0, 1'b0, "R8 imm mod 32");
        apply(2, 32'hF000_0000, 32'h0, 8'd0,   8'd224, 1'b1, 1'b1, "R8 reg multiple of 32");
        // boundary counts for carry taps
        apply(0, 32'h8000_0000, 32'h0, 8'd1,  8'd0, 1'b0, 1'b0, "R1 carry msb n=1");
        apply(3, 32'h8000_0000, 32'h0, 8'd31, 8'd0, 1'b0, 1'b0, "R3 sar n=31");
        apply(8, 32'h0000_0000, 32'h0, 8'd1,  8'd0, 1'b0, 1'b1, "R7 carry into bit0");
        apply(9, 32'h0000_0000, 32'h0, 8'd1,  8'd0, 1'b0, 1'b1, "R7 carry into bit31");
        apply(4, 32'h0000_0000, 32'h8000_0000, 8'd31, 8'd0, 1'b0, 1'b0, "R4 fill n=31");
        apply(5, 32'h0000_0000, 32'h0000_0001, 8'd31, 8'd0, 1'b0, 1'b0, "R5 fill n=31");
        apply(12, 32'hA5A5_5A5A, 32'h0, 8'd3, 8'd0, 1'b0, 1'b1, "R10 illegal");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang exp finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule